// File: doc/BRIEF.md
# ADC Power-Up Initialization Sequencer

This block governs the digital output path of a two-channel converter around power-down and the start-up that follows. While the active-low power-down input is held low, both sample outputs read zero and the decimation filter reset is asserted. Once power-down is released, the block waits for a qualifying frame-clock edge. The polarity of that edge can be selected. From that edge it counts a fixed number of frame periods and keeps the sample outputs at zero for the whole count. It then passes live samples through.

The count length depends on the interface role. A master runs 516 frame periods and a slave runs 517. The frame clock is asynchronous to the system clock, so it is synchronized with two flops before its edges are detected. A state indicator tells the surrounding logic which phase the block is in.

Top module: `adc_init_seq`

## Requirements
- R1: While `pwr_dn_ni` is low, `state_o` is 0 (power-down) from the next clock, `filt_rst_o` is 1 and both sample outputs are zero.
- R2: With `state_o` at 0 and `pwr_dn_ni` high at a clock edge, `state_o` becomes 1 (wait-for-edge) at that edge and `filt_rst_o` drops to 0.
- R3: With `edge_fall_i` = 0, only a rising frame-clock edge moves the block from state 1 to state 2 (init). A falling edge leaves it in state 1, and the outputs stay zero.
- R4: With `edge_fall_i` = 1, a falling frame-clock edge moves the block from state 1 to state 2.
- R5: The block enters state 2 on the third rising system-clock edge after the frame-clock transition, not on the second.
- R6: With `slave_mode_i` = 0, the block stays in state 2 with zero outputs for 515 further qualifying edges after the starting edge. It enters state 3 (run) on the 516th.
- R7: With `slave_mode_i` = 1, the block enters state 3 on the 517th qualifying edge after the starting edge, and not earlier.
- R8: In state 3, `ch0_data_o` and `ch1_data_o` follow `ch0_data_i` and `ch1_data_i` in the same cycle, and `filt_rst_o` is 0.
- R9: A low on `pwr_dn_ni` in any state returns `state_o` to 0 at the next clock edge.
- R10: A low on `rst_ni` puts the block in state 0 at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_dn_ni | input | 1 | Active-low power-down request |
| frame_clk_i | input | 1 | Frame clock, asynchronous to clk_i |
| slave_mode_i | input | 1 | 1 selects the slave-mode init length (517), 0 selects master (516) |
| edge_fall_i | input | 1 | 1 makes the falling frame-clock edge qualify, 0 the rising edge |
| ch0_data_i | input | DATA_W | Channel 0 sample in |
| ch1_data_i | input | DATA_W | Channel 1 sample in |
| ch0_data_o | output | DATA_W | Channel 0 sample out, zero unless running |
| ch1_data_o | output | DATA_W | Channel 1 sample out, zero unless running |
| filt_rst_o | output | 1 | Filter reset, high in power-down |
| state_o | output | 2 | 0 power-down, 1 wait-edge, 2 init, 3 run |

## Verification
A change on `pwr_dn_ni` shows on `state_o` one clock later. A frame-clock transition reaches the state register three clocks after it is driven: two synchronizer flops, then the state flop. Sample gating follows the state register in the same cycle. The bench changes every input on the falling system-clock edge and waits exactly one falling edge for power-down effects and three for frame-edge effects before it samples. It holds each frame-clock level for four clocks, so every edge has settled before the next one is driven. The init length is checked one edge short of the terminal count and again at the terminal count, for both roles and both edge polarities.

// File: rtl/adc_init_pkg.sv
package adc_init_pkg;
  typedef enum logic [1:0] {
    ST_PD   = 2'd0,
    ST_WAIT = 2'd1,
    ST_INIT = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/frame_edge_det.sv
module frame_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_clk_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES:0] pipe_q;
  logic synced, prev, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], frame_clk_i};
  end

  assign synced = pipe_q[SYNC_STAGES-1];
  assign prev   = pipe_q[SYNC_STAGES];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;
  assign edge_o = fall_sel_i ? fall : rise;
endmodule

// File: rtl/init_counter.sv
module init_counter #(
  parameter int CNT_W      = 10,
  parameter int MASTER_LEN = 516,
  parameter int SLAVE_LEN  = 517
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             slave_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MASTER_LAST = CNT_W'(MASTER_LEN - 1);
  localparam logic [CNT_W-1:0] SLAVE_LAST  = CNT_W'(SLAVE_LEN - 1);

  logic [CNT_W-1:0] cnt_q, last;

  assign last = slave_i ? SLAVE_LAST : MASTER_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done_o = inc_i & (cnt_q == last);
  assign cnt_o  = cnt_q;

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq
  import adc_init_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CNT_W      = 10,
  parameter int MASTER_LEN = 516,
  parameter int SLAVE_LEN  = 517
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_dn_ni,
  input  logic              frame_clk_i,
  input  logic              slave_mode_i,
  input  logic              edge_fall_i,
  input  logic [DATA_W-1:0] ch0_data_i,
  input  logic [DATA_W-1:0] ch1_data_i,
  output logic [DATA_W-1:0] ch0_data_o,
  output logic [DATA_W-1:0] ch1_data_o,
  output logic              filt_rst_o,
  output logic [1:0]        state_o
);
  localparam logic [CNT_W-1:0] M_LAST = CNT_W'(MASTER_LEN - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SLAVE_LEN - 1);

  seq_state_e       state_q, state_d;
  logic             frm_edge, cnt_done;
  logic [CNT_W-1:0] cnt;

  frame_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_clk_i (frame_clk_i),
    .fall_sel_i  (edge_fall_i),
    .edge_o      (frm_edge)
  );

  init_counter #(
    .CNT_W      (CNT_W),
    .MASTER_LEN (MASTER_LEN),
    .SLAVE_LEN  (SLAVE_LEN)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q != ST_INIT),
    .inc_i   (frm_edge && (state_q == ST_INIT)),
    .slave_i (slave_mode_i),
    .done_o  (cnt_done),
    .cnt_o   (cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PD:   state_d = ST_WAIT;
      ST_WAIT: if (frm_edge) state_d = ST_INIT;
      ST_INIT: if (cnt_done) state_d = ST_RUN;
      ST_RUN:  state_d = ST_RUN;
      default: state_d = ST_PD;
    endcase
    if (!pwr_dn_ni) state_d = ST_PD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PD;
    else         state_q <= state_d;
  end

  // zero both channels outside run
  assign ch0_data_o = (state_q == ST_RUN) ? ch0_data_i : '0;
  assign ch1_data_o = (state_q == ST_RUN) ? ch1_data_i : '0;
  assign filt_rst_o = (state_q == ST_PD);
  assign state_o    = state_q;

  assert_pd_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |=> (state_q == ST_PD));

  assert_pd_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD && pwr_dn_ni) |=> (state_q == ST_WAIT));

  assert_init_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && pwr_dn_ni && frm_edge) |=> (state_q == ST_INIT));

  assert_run_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && pwr_dn_ni && frm_edge &&
     cnt == (slave_mode_i ? S_LAST : M_LAST)) |=> (state_q == ST_RUN));

  assert_run_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && pwr_dn_ni && !frm_edge) |=> (state_q == ST_INIT));
endmodule

// File: tb/adc_init_seq_tb_top.sv
module adc_init_seq_tb_top;
  localparam int DW = 24;
  localparam int unsigned V_SLAVE [4] = '{0, 1, 0, 1};
  localparam int unsigned V_FALL  [4] = '{0, 0, 1, 1};
  localparam int unsigned V_LEN   [4] = '{516, 517, 516, 517};
  localparam logic [DW-1:0] V_D0  [4] = '{24'h5A5A5A, 24'h123456, 24'hFFFFFF, 24'h800001};
  localparam logic [DW-1:0] V_D1  [4] = '{24'hA1B2C3, 24'h7FFFFF, 24'h000001, 24'h0F0F0F};

  logic clk = 1'b0, rst_n = 1'b0, pwr_dn_n = 1'b0, frame = 1'b0;
  logic slave = 1'b0, fall = 1'b0;
  logic [DW-1:0] d0 = '0, d1 = '0, q0, q1;
  logic filt_rst;
  logic [1:0] st;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  adc_init_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_dn_ni(pwr_dn_n), .frame_clk_i(frame),
    .slave_mode_i(slave), .edge_fall_i(fall), .ch0_data_i(d0), .ch1_data_i(d1),
    .ch0_data_o(q0), .ch1_data_o(q1), .filt_rst_o(filt_rst), .state_o(st)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_frame(input logic v);
    @(negedge clk);
    frame = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    summary();
    $finish;
  end

  initial begin
    d0 = 24'h333333; d1 = 24'h444444;
    #1;
    chk("R10", "state in reset", 64'(st), 64'd0);
    chk("R1", "filt_rst in reset", 64'(filt_rst), 64'd1);
    chk("R1", "ch0 in reset", 64'(q0), 64'd0);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1", "state while pwr_dn low", 64'(st), 64'd0);

    for (int v = 0; v < 4; v++) begin
      logic inact;
      string lreq;
      inact = (V_FALL[v] != 0);
      lreq  = (V_SLAVE[v] != 0) ? "R7" : "R6";
      @(negedge clk);
      pwr_dn_n = 1'b0;
      slave = V_SLAVE[v][0];
      fall  = V_FALL[v][0];
      frame = inact;
      d0 = V_D0[v]; d1 = V_D1[v];
      wait_n(4);
      chk("R1", "state pd", 64'(st), 64'd0);
      chk("R1", "filt_rst pd", 64'(filt_rst), 64'd1);
      chk("R1", "ch1 pd", 64'(q1), 64'd0);
      pwr_dn_n = 1'b1;
      wait_n(1);
      chk("R2", "state after release", 64'(st), 64'd1);
      chk("R2", "filt_rst after release", 64'(filt_rst), 64'd0);
      set_frame(~inact);
      wait_n(3);
      chk(inact ? "R4" : "R3", "state after start edge", 64'(st), 64'd2);
      wait_n(1);
      set_frame(inact);
      wait_n(4);
      for (int k = 1; k <= int'(V_LEN[v]); k++) begin
        set_frame(~inact);
        wait_n(3);
        if (k == int'(V_LEN[v]) - 1) begin
          chk(lreq, "state one edge short", 64'(st), 64'd2);
          chk(lreq, "ch0 zero in init", 64'(q0), 64'd0);
        end
        if (k == int'(V_LEN[v])) begin
          chk(lreq, "state at terminal", 64'(st), 64'd3);
          chk("R8", "ch0 pass", 64'(q0), 64'(V_D0[v]));
          chk("R8", "ch1 pass", 64'(q1), 64'(V_D1[v]));
          chk("R8", "filt_rst run", 64'(filt_rst), 64'd0);
        end
        wait_n(1);
        set_frame(inact);
        wait_n(4);
      end
    end

    // R8: same-cycle follow in run
    @(negedge clk);
    d0 = 24'h0A0B0C;
    #1;
    chk("R8", "ch0 follows", 64'(q0), 64'h0A0B0C);

    // R9: power-down from run
    @(negedge clk);
    pwr_dn_n = 1'b0;
    wait_n(1);
    chk("R9", "state from run", 64'(st), 64'd0);
    chk("R9", "filt_rst from run", 64'(filt_rst), 64'd1);

    // R3 wrong polarity ignored, R5 sync latency
    slave = 1'b0; fall = 1'b0; frame = 1'b1;
    wait_n(4);
    pwr_dn_n = 1'b1;
    wait_n(1);
    set_frame(1'b0);
    wait_n(4);
    chk("R3", "falling edge ignored", 64'(st), 64'd1);
    chk("R3", "ch0 zero in wait", 64'(q0), 64'd0);
    set_frame(1'b1);
    wait_n(2);
    chk("R5", "state two clocks after edge", 64'(st), 64'd1);
    wait_n(1);
    chk("R5", "state three clocks after edge", 64'(st), 64'd2);

    // R9: power-down from init
    wait_n(2);
    pwr_dn_n = 1'b0;
    wait_n(1);
    chk("R9", "state from init", 64'(st), 64'd0);

    // R10: async reset without clock edge
    pwr_dn_n = 1'b1;
    wait_n(3);
    chk("R2", "state wait before reset", 64'(st), 64'd1);
    #2 rst_n = 1'b0;
    #1;
    chk("R10", "state async reset", 64'(st), 64'd0);
    chk("R10", "filt_rst async reset", 64'(filt_rst), 64'd1);
    wait_n(2);
    rst_n = 1'b1;
    wait_n(2);

    summary();
    $finish;
  end
endmodule